// File: doc/BRIEF.md
# Receiver Detect and Status Reporter

This block sits on the PHY side of a serial link. When asked, it checks whether a far-end receiver is attached to the transmit lane. It also reports receive-side conditions on a 3-bit status bus. A detection run is started by a one-cycle request. The block then holds the lane at a first level for a fixed number of cycles and switches it to a second level. It counts the cycles until a sampled line comparator changes state. A slow change means a load capacitance is present, so the far end is declared present. A fast change means the far end is absent. If no change arrives before the timeout, the run also ends as present. The analog driver and the comparator are modelled as plain digital signals.

The end of a detection run is marked by a single-cycle completion strobe. The same strobe also acknowledges power-state changes. The status bus has two formats. In the encoded format, one 3-bit code is shown. During the strobe cycle that code is the detection result. At all other times it is the highest-priority receive error seen in the previous cycle. In the per-bit format, each bit is a sticky flag for one out-of-band event and stays set until a clear pulse.

Top module: `rxdet_top`

## Requirements
- R1: After reset: `tx_det_active`, `tx_det_level`, `det_busy` and `phy_done` are 0, and `rx_code` is 000 in encoded format (`mode_sata`=0).
- R2: A `det_req` pulse taken at an edge raises `tx_det_active` from that edge on. `tx_det_level` stays 0 (first level) for PRE_CYC cycles and is then 1 (second level) until the run ends.
- R3: Let d be the number of cycles the second level has been held, counted from 0, when `line_sense` is first seen to differ from its previous sample. The far end is present if d >= THRESH and absent otherwise. `phy_done` rises one cycle after that sample, with `rx_code` 011 for present and 000 for absent in encoded format.
- R4: If `line_sense` does not change within TIMEOUT cycles of the second level, the run ends as present: `phy_done` pulses TIMEOUT cycles after the level switch, with code 011.
- R5: `det_req` pulses while `det_busy` is 1 are ignored. A run produces exactly one strobe, and the block is idle afterwards.
- R6: The completion strobe lasts exactly one cycle. The detection result appears on `rx_code` only in that cycle.
- R7: In encoded format outside the strobe cycle, `rx_code` shows the errors sampled at the previous edge: 000 none, 100 decode error, 101 elastic overflow, 110 elastic underflow, 111 disparity error. Codes 001 and 010 are never driven.
- R8: When several errors arrive together, the code follows the priority disparity > overflow > underflow > decode.
- R9: In per-bit format, bit 0 is the out-of-band transmit done flag, bit 1 the wake flag and bit 2 the reset/init flag. Each bit sets one cycle after its event and stays set until `sata_clr`. A clear wins over an event in the same cycle.
- R10: `mode_sata` is only taken while no detection is running. A change during a run takes effect after the strobe cycle.
- R11: A `pwr_done` pulse produces a one-cycle `phy_done` one cycle later, and `rx_code` is left unchanged.
- R12: In per-bit format, a detection run still strobes `phy_done`, and `rx_code` keeps showing the sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sata | input | 1 | 0 encoded format, 1 per-bit format |
| det_req | input | 1 | One-cycle detection request |
| line_sense | input | 1 | Sampled line comparator |
| pwr_done | input | 1 | Power-state change completed |
| err_dec | input | 1 | 8b/10b decode error event |
| err_ovf | input | 1 | Elastic buffer overflow event |
| err_unf | input | 1 | Elastic buffer underflow event |
| err_disp | input | 1 | Disparity error event |
| sata_oob_done | input | 1 | Transmitted out-of-band sequence done |
| sata_wake | input | 1 | Wake signal received |
| sata_reset | input | 1 | Reset/init signal received |
| sata_clr | input | 1 | Clears the sticky per-bit flags |
| tx_det_active | output | 1 | Lane driven by the detector |
| tx_det_level | output | 1 | 0 first level, 1 second level |
| det_busy | output | 1 | Detection run in progress |
| phy_done | output | 1 | One-cycle completion strobe |
| rx_code | output | 3 | Status bus |

## Verification
A wrong cycle counter or phase counter shows at the ports within one run. The level switch moves away from PRE_CYC cycles, or the present/absent verdict flips on the sweep of d across THRESH. A stuck sequencer state shows as a missing or doubled strobe, or as `det_busy` staying high, within a cycle or two of the expected strobe. Corrupt error-priority or sticky-flag registers show on `rx_code` one cycle after the event that exposes them.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_MEAS = 2'd2
    } det_state_e;

    typedef enum logic {
        FMT_PCIE = 1'b0,
        FMT_SATA = 1'b1
    } stat_fmt_e;

    localparam logic [2:0] CODE_OK      = 3'b000;
    localparam logic [2:0] CODE_ABSENT  = 3'b000;
    localparam logic [2:0] CODE_PRESENT = 3'b011;
    localparam logic [2:0] CODE_DEC     = 3'b100;
    localparam logic [2:0] CODE_OVF     = 3'b101;
    localparam logic [2:0] CODE_UNF     = 3'b110;
    localparam logic [2:0] CODE_DISP    = 3'b111;

    typedef struct packed {
        logic disp;
        logic ovf;
        logic unf;
        logic dec;
    } rx_err_t;

    // bit 2 reset/init, bit 1 wake, bit 0 oob transmit done
    typedef struct packed {
        logic reset_in;
        logic wake_in;
        logic oob_done;
    } sata_ev_t;

    function automatic logic [2:0] err_encode(input rx_err_t e);
        logic [2:0] c;
        if (e.disp)      c = CODE_DISP;
        else if (e.ovf)  c = CODE_OVF;
        else if (e.unf)  c = CODE_UNF;
        else if (e.dec)  c = CODE_DEC;
        else             c = CODE_OK;
        return c;
    endfunction

endpackage

// File: rtl/rxdet_seq.sv
module rxdet_seq
    import rxdet_pkg::*;
#(
    parameter int THRESH  = 16,
    parameter int TIMEOUT = 1024,
    parameter int PRE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic det_req,
    input  logic line_sense,
    output logic busy,
    output logic drive_active,
    output logic drive_level,
    output logic det_done,
    output logic det_present
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam int PW = (PRE_CYC > 2) ? $clog2(PRE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
    localparam logic [CW-1:0] CNT_TH   = CW'(THRESH);
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_CYC - 1);

    det_state_e    state;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic          sense_q;
    logic          done_q;
    logic          present_q;
    logic          edge_seen;

    assign edge_seen = (line_sense != sense_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            pcnt      <= '0;
            sense_q   <= 1'b0;
            done_q    <= 1'b0;
            present_q <= 1'b0;
        end else begin
            sense_q <= line_sense;
            done_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (det_req) begin
                        state <= ST_PRE;
                        pcnt  <= '0;
                    end
                end
                ST_PRE: begin
                    if (pcnt == PRE_LAST) begin
                        state <= ST_MEAS;
                        cnt   <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                ST_MEAS: begin
                    if (edge_seen) begin
                        done_q    <= 1'b1;
                        present_q <= (cnt >= CNT_TH);
                        state     <= ST_IDLE;
                    end else if (cnt == CNT_LAST) begin
                        done_q    <= 1'b1;
                        present_q <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign drive_active = busy;
    assign drive_level  = (state == ST_MEAS);
    assign det_done     = done_q;
    assign det_present  = present_q;

    assert_start_by_req_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |-> $past(det_req));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_idle_at_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy);

    assert_meas_after_pre_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MEAS && $past(state) != ST_MEAS) |-> $past(state) == ST_PRE);

endmodule

// File: rtl/rxdet_stat.sv
module rxdet_stat
    import rxdet_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stat_fmt_e fmt,
    input  rx_err_t   err,
    input  sata_ev_t  sev,
    input  logic      sata_clr,
    input  logic      det_done,
    input  logic      det_present,
    input  logic      pwr_done,
    output logic      phy_done,
    output logic [2:0] rx_code
);
    logic [2:0] err_code_q;
    logic [2:0] sata_q;
    logic [2:0] ev_bits;
    logic       pwr_q;

    assign ev_bits = sev;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_code_q <= CODE_OK;
            pwr_q      <= 1'b0;
        end else begin
            err_code_q <= err_encode(err);
            pwr_q      <= pwr_done;
        end
    end

    for (genvar i = 0; i < 3; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst || sata_clr) sata_q[i] <= 1'b0;
            else if (ev_bits[i]) sata_q[i] <= 1'b1;
        end
    end

    always_comb begin
        if (fmt == FMT_PCIE) begin
            if (det_done) rx_code = det_present ? CODE_PRESENT : CODE_ABSENT;
            else          rx_code = err_code_q;
        end else begin
            rx_code = sata_q;
        end
    end

    assign phy_done = det_done | pwr_q;

    assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_PCIE) |-> (rx_code != 3'b001 && rx_code != 3'b010));

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !sata_clr |=> ((sata_q & $past(sata_q)) == $past(sata_q)));

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        sata_clr |=> (sata_q == 3'b000));

    assert_pwr_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_done |=> phy_done);

endmodule

// File: rtl/rxdet_top.sv
module rxdet_top
    import rxdet_pkg::*;
#(
    parameter int THRESH  = 16,
    parameter int TIMEOUT = 1024,
    parameter int PRE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sata,
    input  logic       det_req,
    input  logic       line_sense,
    input  logic       pwr_done,
    input  logic       err_dec,
    input  logic       err_ovf,
    input  logic       err_unf,
    input  logic       err_disp,
    input  logic       sata_oob_done,
    input  logic       sata_wake,
    input  logic       sata_reset,
    input  logic       sata_clr,
    output logic       tx_det_active,
    output logic       tx_det_level,
    output logic       det_busy,
    output logic       phy_done,
    output logic [2:0] rx_code
);
    stat_fmt_e mode_q;
    logic      busy;
    logic      det_done;
    logic      det_present;
    rx_err_t   err;
    sata_ev_t  sev;

    assign err = '{disp: err_disp, ovf: err_ovf, unf: err_unf, dec: err_dec};
    assign sev = '{reset_in: sata_reset, wake_in: sata_wake, oob_done: sata_oob_done};

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= FMT_PCIE;
        else if (!busy) mode_q <= stat_fmt_e'(mode_sata);
    end

    rxdet_seq #(
        .THRESH (THRESH),
        .TIMEOUT(TIMEOUT),
        .PRE_CYC(PRE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .det_req     (det_req),
        .line_sense  (line_sense),
        .busy        (busy),
        .drive_active(tx_det_active),
        .drive_level (tx_det_level),
        .det_done    (det_done),
        .det_present (det_present)
    );

    rxdet_stat u_stat (
        .clk        (clk),
        .rst        (rst),
        .fmt        (mode_q),
        .err        (err),
        .sev        (sev),
        .sata_clr   (sata_clr),
        .det_done   (det_done),
        .det_present(det_present),
        .pwr_done   (pwr_done),
        .phy_done   (phy_done),
        .rx_code    (rx_code)
    );

    assign det_busy = busy;

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(mode_q));

endmodule

// File: tb/rxdet_top_test.sv
module rxdet_top_test;
    localparam int THRESH  = 16;
    localparam int TIMEOUT = 1024;
    localparam int PRE_CYC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sata = 0, det_req = 0, line_sense = 0, pwr_done = 0;
    logic err_dec = 0, err_ovf = 0, err_unf = 0, err_disp = 0;
    logic sata_oob_done = 0, sata_wake = 0, sata_reset = 0, sata_clr = 0;
    logic tx_det_active, tx_det_level, det_busy, phy_done;
    logic [2:0] rx_code;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rxdet_top #(.THRESH(THRESH), .TIMEOUT(TIMEOUT), .PRE_CYC(PRE_CYC)) uut (
        .clk(clk), .rst(rst), .mode_sata(mode_sata), .det_req(det_req),
        .line_sense(line_sense), .pwr_done(pwr_done), .err_dec(err_dec),
        .err_ovf(err_ovf), .err_unf(err_unf), .err_disp(err_disp),
        .sata_oob_done(sata_oob_done), .sata_wake(sata_wake),
        .sata_reset(sata_reset), .sata_clr(sata_clr),
        .tx_det_active(tx_det_active), .tx_det_level(tx_det_level),
        .det_busy(det_busy), .phy_done(phy_done), .rx_code(rx_code)
    );

    task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Starts a run, checks the first-level phase, leaves the caller at the
    // negedge where the second level is first seen (index 0).
    task automatic start_run(input string req);
        det_req = 1'b1;
        @(negedge clk);
        det_req = 1'b0;
        for (int i = 0; i < PRE_CYC; i++) begin
            chk({1'b0, tx_det_active, tx_det_level}, 3'b010, req);
            @(negedge clk);
        end
        chk({1'b0, tx_det_active, tx_det_level}, 3'b011, req);
    endtask

    // Holds the second level d cycles, flips the comparator, checks strobe.
    task automatic run_with_delay(input int d, input logic [2:0] exp_code, input string req);
        start_run(req);
        repeat (d) begin
            chk({2'b00, phy_done}, 3'b000, req);
            @(negedge clk);
        end
        line_sense = ~line_sense;
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b001, req);
        chk(rx_code, exp_code, req);
        chk({2'b00, det_busy}, 3'b000, req);
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b000, "R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({tx_det_active, tx_det_level, det_busy}, 3'b000, "R1");
        chk({2'b00, phy_done}, 3'b000, "R1");
        chk(rx_code, 3'b000, "R1");

        // R2 R3 sweep of comparator delay across the threshold
        for (int d = 0; d <= THRESH + 24; d++) begin
            run_with_delay(d, (d >= THRESH) ? 3'b011 : 3'b000, "R3");
            chk(rx_code, 3'b000, "R6");
        end

        // R4 timeout without comparator change
        start_run("R4");
        repeat (TIMEOUT - 1) @(negedge clk);
        chk({2'b00, phy_done}, 3'b000, "R4");
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b001, "R4");
        chk(rx_code, 3'b011, "R4");
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b000, "R6");

        // R5 requests while busy are ignored
        start_run("R5");
        det_req = 1'b1;
        @(negedge clk);
        det_req = 1'b0;
        repeat (THRESH + 3) @(negedge clk);
        line_sense = ~line_sense;
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b001, "R5");
        chk(rx_code, 3'b011, "R5");
        repeat (2) @(negedge clk);
        chk({1'b0, det_busy, phy_done}, 3'b000, "R5");

        // R7 R8 exhaustive error combinations
        for (int v = 0; v < 16; v++) begin
            logic [2:0] e;
            e = v[3] ? 3'b111 : v[2] ? 3'b101 : v[1] ? 3'b110 : v[0] ? 3'b100 : 3'b000;
            {err_disp, err_ovf, err_unf, err_dec} = 4'(v);
            @(negedge clk);
            {err_disp, err_ovf, err_unf, err_dec} = 4'b0;
            chk(rx_code, e, (v[3] + v[2] + v[1] + v[0] > 1) ? "R8" : "R7");
            @(negedge clk);
            chk(rx_code, 3'b000, "R7");
        end

        // R11 power-state completion
        err_ovf = 1'b1;
        pwr_done = 1'b1;
        @(negedge clk);
        err_ovf = 1'b0;
        pwr_done = 1'b0;
        chk({2'b00, phy_done}, 3'b001, "R11");
        chk(rx_code, 3'b101, "R11");
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b000, "R11");

        // R9 per-bit format, sticky flags
        mode_sata = 1'b1;
        sata_clr = 1'b1;
        @(negedge clk);
        sata_clr = 1'b0;
        @(negedge clk);
        chk(rx_code, 3'b000, "R9");
        for (int v = 0; v < 8; v++) begin
            {sata_reset, sata_wake, sata_oob_done} = 3'(v);
            @(negedge clk);
            {sata_reset, sata_wake, sata_oob_done} = 3'b000;
            chk(rx_code, 3'(v), "R9");
            repeat (3) @(negedge clk);
            chk(rx_code, 3'(v), "R9");
            sata_wake = 1'b1;
            @(negedge clk);
            sata_wake = 1'b0;
            chk(rx_code, 3'(v) | 3'b010, "R9");
            sata_clr = 1'b1;
            sata_reset = 1'b1;
            @(negedge clk);
            sata_clr = 1'b0;
            sata_reset = 1'b0;
            chk(rx_code, 3'b000, "R9");
        end

        // R12 detection in per-bit format keeps flags on the bus
        sata_oob_done = 1'b1;
        @(negedge clk);
        sata_oob_done = 1'b0;
        run_with_delay(THRESH + 2, 3'b001, "R12");

        // R10 mode change during a run applies after the strobe cycle
        sata_reset = 1'b1;
        @(negedge clk);
        sata_reset = 1'b0;
        mode_sata = 1'b0;
        @(negedge clk);
        chk(rx_code, 3'b000, "R10");
        start_run("R10");
        mode_sata = 1'b1;
        repeat (THRESH + 1) @(negedge clk);
        line_sense = ~line_sense;
        @(negedge clk);
        chk({2'b00, phy_done}, 3'b001, "R10");
        chk(rx_code, 3'b011, "R10");
        @(negedge clk);
        @(negedge clk);
        chk(rx_code, 3'b101, "R10");

        finish_run();
    end
endmodule